// File: doc/BRIEF.md
# Adaptive Harmonic Coefficient Estimator

This block tracks the Fourier coefficients of a sampled AC voltage with a least-mean-squares adaptive linear neuron. On each sample strobe it captures the measured voltage and a basis vector. The basis vector holds one constant term plus the cosine and sine of the fundamental and of each harmonic up to `NH`. The block forms the estimate as the dot product of the basis with its weight vector and takes the error between the measurement and that estimate. It then moves every weight by the error times its basis value, scaled down by a power of two. A table or oscillator outside the block supplies the basis values, and a downstream voltage or droop controller takes the results.

One shared multiplier does all of the arithmetic, one step per clock: first the dot product, then each weight update, then the squared magnitude of the fundamental. A configuration input chooses whether the fundamental amplitude comes out as that squared magnitude or as its integer square root, and the `amp_sq` flag marks the form. With the default parameters the whole job takes under fifty clocks. That leaves a wide margin inside a 10 us sample period at 100 MHz.

Number formats: samples and estimates are signed integers. Basis values are signed with 1.0 = 2^(DW-2). Weights are in sample units with FRAC fractional bits.

Top module: `adaline_est`

## Requirements
- R1: While reset is asserted, and afterwards until the first strobe, every weight, `est_y`, `est_err` and `amp` is zero, and `busy`, `done` and `amp_sq` are low.
- R2: A strobe seen while idle captures `smp_y`, the basis, `mu_shift` and `root_mode`. `busy` is high from the following cycle. `done` then pulses high for exactly one cycle within 2*(2*NH+1)+WW+4 cycles, with `busy` low in that cycle.
- R3: `est_y` equals floor(sum of w_i*x_i / 2^(FRAC+DW-2)), using the weights held before the update and saturated to DW+2 signed bits.
- R4: `est_err` equals `smp_y` minus `est_y`, saturated to DW+2 signed bits.
- R5: Each weight becomes w_i + floor(est_err*x_i / 2^(DW-2-FRAC+mu_shift)). The result saturates at the signed WW-bit rails instead of wrapping.
- R6: The basis and weight order is fixed. Index 0 is the DC term with a constant basis of 2^(DW-2). Index 2n-1 is the cosine coefficient of harmonic n, taken from `cos_in[(n-1)*DW +: DW]`. Index 2n is the sine coefficient, taken from `sin_in[(n-1)*DW +: DW]`. Weight i sits at `weights[i*WW +: WW]`.
- R7: When `done` pulses, `amp` holds the fundamental's cosine and sine weights (indices 1 and 2) after the update. With `root_mode` = 0, `amp` is A1^2+B1^2 and `amp_sq` = 1. With `root_mode` = 1, `amp` is floor(sqrt(A1^2+B1^2)) and `amp_sq` = 0.
- R8: A strobe that arrives while `busy` is high is ignored. It causes no extra `done`, and it changes neither the results nor the weights.
- R9: While idle with no strobe, the weights, `est_y`, `est_err` and `amp` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe |
| smp_y | input | DW | Measured voltage sample, signed |
| cos_in | input | NH*DW | Cosine basis values, harmonic n in slice n-1 |
| sin_in | input | NH*DW | Sine basis values, harmonic n in slice n-1 |
| mu_shift | input | SW | Extra right shift applied to the update step |
| root_mode | input | 1 | 1: output the amplitude, 0: output its square |
| busy | output | 1 | A sample is being processed |
| done | output | 1 | One-cycle pulse when the results are valid |
| est_y | output | DW+2 | Estimated sample, signed |
| est_err | output | DW+2 | Estimation error, signed |
| weights | output | (2*NH+1)*WW | Weight vector, signed entries |
| amp | output | 2*WW | Fundamental amplitude or squared amplitude |
| amp_sq | output | 1 | `amp` holds the squared magnitude |

## Verification
The assertions assume that `smp_y` carries a known value in any cycle where the strobe is accepted, since the checker keeps its own copy of that sample to judge the error. They also assume that the weights do not move between the last update and `done`, which is how the amplitude checks read them. The stimulus gives a defined sample with every strobe. It keeps basis values inside plus or minus 1.0, with the exception of one deliberately unrealistic all-ones pattern used to drive the weights into the rails. It also places one stray strobe inside a busy window to show that the block ignores it.

// File: rtl/adaline_est.sv
module adaline_est #(
  parameter int DW   = 16,
  parameter int NH   = 4,
  parameter int WW   = 24,
  parameter int FRAC = 8,
  parameter int SW   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic signed [DW-1:0]      smp_y,
  input  logic [NH*DW-1:0]          cos_in,
  input  logic [NH*DW-1:0]          sin_in,
  input  logic [SW-1:0]             mu_shift,
  input  logic                      root_mode,
  output logic                      busy,
  output logic                      done,
  output logic signed [DW+1:0]      est_y,
  output logic signed [DW+1:0]      est_err,
  output logic [(2*NH+1)*WW-1:0]    weights,
  output logic [2*WW-1:0]           amp,
  output logic                      amp_sq
);
  localparam int K    = 2*NH + 1;
  localparam int EW   = DW + 2;
  localparam int AW   = 2*WW;
  localparam int ACCW = AW + $clog2(K);
  localparam int IW   = $clog2(K);
  localparam int RW   = $clog2(WW);
  localparam int YSH  = FRAC + DW - 2;
  localparam int USH  = DW - 2 - FRAC;

  localparam logic signed [ACCW-1:0] EMAX = ACCW'($signed({1'b0, {(EW-1){1'b1}}}));
  localparam logic signed [ACCW-1:0] EMIN = ACCW'($signed({1'b1, {(EW-1){1'b0}}}));
  localparam logic signed [AW:0]     WMAX = (AW+1)'($signed({1'b0, {(WW-1){1'b1}}}));
  localparam logic signed [AW:0]     WMIN = (AW+1)'($signed({1'b1, {(WW-1){1'b0}}}));

  typedef enum logic [2:0] {S_IDLE, S_DOT, S_ERR, S_UPD, S_MAG0, S_MAG1, S_ROOT} st_t;

  function automatic logic signed [EW-1:0] sat_e(input logic signed [ACCW-1:0] v);
    if (v > EMAX)      return {1'b0, {(EW-1){1'b1}}};
    else if (v < EMIN) return {1'b1, {(EW-1){1'b0}}};
    else               return v[EW-1:0];
  endfunction

  function automatic logic signed [WW-1:0] sat_w(input logic signed [AW:0] v);
    if (v > WMAX)      return {1'b0, {(WW-1){1'b1}}};
    else if (v < WMIN) return {1'b1, {(WW-1){1'b0}}};
    else               return v[WW-1:0];
  endfunction

  st_t                     st;
  logic [IW-1:0]           idx;
  logic [RW-1:0]           cnt;
  logic signed [DW-1:0]    xin [K];
  logic signed [DW-1:0]    xr  [K];
  logic signed [WW-1:0]    w   [K];
  logic signed [DW-1:0]    yr;
  logic [SW-1:0]           mu_r;
  logic                    root_r;
  logic signed [EW-1:0]    err_r;
  logic signed [ACCW-1:0]  acc;
  logic [AW-1:0]           sq, op, res, one;

  logic signed [WW-1:0]    mul_a, mul_b;
  logic signed [AW-1:0]    prod;
  logic signed [EW-1:0]    yhat_s, err_s;
  logic signed [AW-1:0]    dwv;
  logic [7:0]              shamt;
  logic signed [WW-1:0]    w_new;
  logic [AW-1:0]           sq_sum, trial, op_n, res_n;
  logic                    last;

  assign xin[0] = {2'b01, {(DW-2){1'b0}}};
  for (genvar h = 0; h < NH; h++) begin : g_basis
    assign xin[2*h+1] = cos_in[h*DW +: DW];
    assign xin[2*h+2] = sin_in[h*DW +: DW];
  end
  for (genvar g = 0; g < K; g++) begin : g_wout
    assign weights[g*WW +: WW] = w[g];
  end

  always_comb begin
    mul_a = w[idx];
    mul_b = WW'(xr[idx]);
    case (st)
      S_UPD:  mul_a = WW'(err_r);
      S_MAG0: begin mul_a = w[1]; mul_b = w[1]; end
      S_MAG1: begin mul_a = w[2]; mul_b = w[2]; end
      default: ;
    endcase
  end

  assign prod   = mul_a * mul_b;
  assign last   = (idx == IW'(K-1));
  assign yhat_s = sat_e(acc >>> YSH);
  assign err_s  = sat_e(ACCW'(yr) - ACCW'(yhat_s));
  assign shamt  = 8'(USH) + 8'(mu_r);
  assign dwv    = prod >>> shamt;
  assign w_new  = sat_w((AW+1)'(w[idx]) + (AW+1)'(dwv));
  assign sq_sum = sq + $unsigned(prod);
  assign trial  = res + one;
  assign op_n   = (op >= trial) ? op - trial : op;
  assign res_n  = (op >= trial) ? (res >> 1) + one : res >> 1;
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      cnt     <= '0;
      yr      <= '0;
      mu_r    <= '0;
      root_r  <= 1'b0;
      err_r   <= '0;
      acc     <= '0;
      sq      <= '0;
      op      <= '0;
      res     <= '0;
      one     <= '0;
      est_y   <= '0;
      est_err <= '0;
      amp     <= '0;
      amp_sq  <= 1'b0;
      done    <= 1'b0;
      for (int i = 0; i < K; i++) begin
        w[i]  <= '0;
        xr[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (smp_vld) begin
          yr     <= smp_y;
          mu_r   <= mu_shift;
          root_r <= root_mode;
          for (int i = 0; i < K; i++) xr[i] <= xin[i];
          acc    <= '0;
          idx    <= '0;
          st     <= S_DOT;
        end
        S_DOT: begin
          acc <= acc + ACCW'(prod);
          if (last) begin idx <= '0; st <= S_ERR; end
          else idx <= idx + 1'b1;
        end
        S_ERR: begin
          est_y   <= yhat_s;
          est_err <= err_s;
          err_r   <= err_s;
          st      <= S_UPD;
        end
        S_UPD: begin
          w[idx] <= w_new;
          if (last) begin idx <= '0; st <= S_MAG0; end
          else idx <= idx + 1'b1;
        end
        S_MAG0: begin
          sq <= $unsigned(prod);
          st <= S_MAG1;
        end
        S_MAG1: begin
          if (root_r) begin
            op  <= sq_sum;
            res <= '0;
            one <= AW'(1) << (AW-2);
            cnt <= '0;
            st  <= S_ROOT;
          end else begin
            amp    <= sq_sum;
            amp_sq <= 1'b1;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_ROOT: begin
          op  <= op_n;
          res <= res_n;
          one <= one >> 2;
          cnt <= cnt + 1'b1;
          if (cnt == RW'(WW-1)) begin
            amp    <= res_n;
            amp_sq <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adaline_est_chk.sv
module adaline_est_chk #(
  parameter int DW = 16,
  parameter int NH = 4,
  parameter int WW = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_vld,
  input logic signed [DW-1:0]   smp_y,
  input logic                   busy,
  input logic                   done,
  input logic signed [DW+1:0]   est_y,
  input logic signed [DW+1:0]   est_err,
  input logic [(2*NH+1)*WW-1:0] weights,
  input logic [2*WW-1:0]        amp,
  input logic                   amp_sq
);
  localparam int EW = DW + 2;

  logic signed [DW-1:0]   ycap;
  logic signed [EW:0]     diff;
  logic signed [EW-1:0]   err_exp;
  logic signed [WW-1:0]   a1, b1;
  logic signed [2*WW-1:0] pa, pb;
  logic [2*WW:0]          sqv;
  logic [WW-1:0]          r;
  logic [2*WW+1:0]        r2, r12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ycap <= '0;
    else if (smp_vld && !busy)  ycap <= smp_y;
  end

  assign diff    = (EW+1)'(ycap) - (EW+1)'(est_y);
  assign err_exp = (diff > (EW+1)'($signed({1'b0, {(EW-1){1'b1}}}))) ? {1'b0, {(EW-1){1'b1}}} :
                   (diff < (EW+1)'($signed({1'b1, {(EW-1){1'b0}}}))) ? {1'b1, {(EW-1){1'b0}}} :
                   diff[EW-1:0];
  assign a1  = weights[WW +: WW];
  assign b1  = weights[2*WW +: WW];
  assign pa  = a1 * a1;
  assign pb  = b1 * b1;
  assign sqv = {1'b0, pa} + {1'b0, pb};
  assign r   = amp[WW-1:0];
  assign r2  = (2*WW+2)'(r) * (2*WW+2)'(r);
  assign r12 = ((2*WW+2)'(r) + 1'b1) * ((2*WW+2)'(r) + 1'b1);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !busy) |=> busy);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (est_err == err_exp));
  p_square_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && amp_sq) |-> ({1'b0, amp} == sqv));
  p_root_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !amp_sq) |-> ((r2 <= (2*WW+2)'(sqv)) && (r12 > (2*WW+2)'(sqv))));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !smp_vld) |=> ($stable(weights) && $stable(est_y) && $stable(amp)));
endmodule

bind adaline_est adaline_est_chk #(.DW(DW), .NH(NH), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_y(smp_y), .busy(busy),
  .done(done), .est_y(est_y), .est_err(est_err), .weights(weights),
  .amp(amp), .amp_sq(amp_sq)
);

// File: tb/adaline_est_tb.sv
module adaline_est_tb;
  localparam int DW = 16, NH = 4, WW = 24, FRAC = 8, SW = 4;
  localparam int K = 2*NH + 1;
  localparam int EW = DW + 2;

  typedef struct packed {
    logic signed [15:0] y;
    logic signed [15:0] c1, s1, c2, s2, c4;
    logic [3:0]         mu;
    logic               mode;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{ 16'sd1000,   16'sd16384,  16'sd0,      16'sd16384,  16'sd0,      16'sd0,      4'd2, 1'b1},
    '{-16'sd2000,   16'sd11585,  16'sd11585,  16'sd0,      16'sd16384, -16'sd16384,  4'd2, 1'b0},
    '{ 16'sd5000,   16'sd0,      16'sd16384, -16'sd16384,  16'sd0,      16'sd16384,  4'd3, 1'b1},
    '{ 16'sd3000,   16'sd11585, -16'sd11585,  16'sd16384,  16'sd0,      16'sd0,      4'd1, 1'b1},
    '{-16'sd7000,  -16'sd16384,  16'sd0,      16'sd0,     -16'sd16384,  16'sd16384,  4'd4, 1'b0},
    '{ 16'sd12000,  16'sd0,     -16'sd16384,  16'sd11585,  16'sd11585, -16'sd16384,  4'd2, 1'b1},
    '{-16'sd32768,  16'sd16384,  16'sd16384,  16'sd16384,  16'sd16384,  16'sd16384,  4'd0, 1'b1},
    '{ 16'sd32767, -16'sd16384, -16'sd16384, -16'sd16384, -16'sd16384, -16'sd16384,  4'd0, 1'b0}
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   smp_vld = 1'b0;
  logic signed [DW-1:0]   smp_y = '0;
  logic [NH*DW-1:0]       cos_in = '0, sin_in = '0;
  logic [SW-1:0]          mu_shift = '0;
  logic                   root_mode = 1'b0;
  logic                   busy, done, amp_sq;
  logic signed [EW-1:0]   est_y, est_err;
  logic [K*WW-1:0]        weights;
  logic [2*WW-1:0]        amp;

  int n_chk = 0, n_fail = 0, n_done = 0;
  longint mw [K];
  longint cv [NH], sv [NH];
  longint e_y, e_err, e_amp;
  bit     e_sq;

  adaline_est #(.DW(DW), .NH(NH), .WW(WW), .FRAC(FRAC), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_y(smp_y),
    .cos_in(cos_in), .sin_in(sin_in), .mu_shift(mu_shift), .root_mode(root_mode),
    .busy(busy), .done(done), .est_y(est_y), .est_err(est_err),
    .weights(weights), .amp(amp), .amp_sq(amp_sq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) if (done) n_done++;

  function automatic longint sat(longint v, int b);
    longint hi = (64'sd1 <<< (b-1)) - 1;
    longint lo = -(64'sd1 <<< (b-1));
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  function automatic longint isqrt(longint s);
    longint r = 0;
    for (int b = WW-1; b >= 0; b--)
      if (((r | (64'sd1 <<< b)) * (r | (64'sd1 <<< b))) <= s) r = r | (64'sd1 <<< b);
    return r;
  endfunction

  function automatic longint wget(int i);
    return longint'($signed(weights[i*WW +: WW]));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint y, input int mu, input bit mode);
    longint x [K];
    longint acc = 0, s;
    x[0] = 64'sd1 <<< (DW-2);
    for (int h = 0; h < NH; h++) begin x[2*h+1] = cv[h]; x[2*h+2] = sv[h]; end
    for (int i = 0; i < K; i++) acc += mw[i] * x[i];
    e_y   = sat(acc >>> (FRAC+DW-2), EW);
    e_err = sat(y - e_y, EW);
    for (int i = 0; i < K; i++)
      mw[i] = sat(mw[i] + ((e_err * x[i]) >>> (DW-2-FRAC+mu)), WW);
    s = mw[1]*mw[1] + mw[2]*mw[2];
    e_amp = mode ? isqrt(s) : s;
    e_sq  = !mode;
  endtask

  task automatic check_all();
    chk("R3 est_y", longint'(est_y), e_y);
    chk("R4 est_err", longint'(est_err), e_err);
    for (int i = 0; i < K; i++) chk("R5 R6 weight", wget(i), mw[i]);
    chk("R7 amp", longint'(amp), e_amp);
    chk("R7 amp_sq", longint'(amp_sq), longint'(e_sq));
  endtask

  task automatic run_sample(input longint y, input int mu, input bit mode, input bit poke);
    int wd = 0;
    int d0;
    @(negedge clk);
    smp_y = y[DW-1:0];
    for (int h = 0; h < NH; h++) begin
      cos_in[h*DW +: DW] = cv[h][DW-1:0];
      sin_in[h*DW +: DW] = sv[h][DW-1:0];
    end
    mu_shift = SW'(mu); root_mode = mode; smp_vld = 1'b1;
    d0 = n_done;
    @(negedge clk);
    smp_vld = 1'b0; smp_y = '0; cos_in = '1; sin_in = '0;
    mu_shift = ~SW'(mu); root_mode = ~mode;
    chk("R2 busy after strobe", longint'(busy), 1);
    model(y, mu, mode);
    if (poke) begin
      repeat (3) @(negedge clk);
      smp_vld = 1'b1; smp_y = 16'sd1234; sin_in = '1;
      @(negedge clk);
      smp_vld = 1'b0;
    end
    while (!done && wd < 2*K + WW + 4) begin @(negedge clk); wd++; end
    chk("R2 done within bound", longint'(done), 1);
    chk("R2 idle at done", longint'(busy), 0);
    check_all();
    if (poke) begin
      repeat (40) @(negedge clk);
      chk("R8 no extra done", longint'(n_done - d0), 1);
      chk("R8 busy low", longint'(busy), 0);
      for (int i = 0; i < K; i++) chk("R8 weight kept", wget(i), mw[i]);
    end
  endtask

  task automatic set_basis(input longint c1, s1, c2, s2, c3, s3, c4, s4);
    cv[0] = c1; sv[0] = s1; cv[1] = c2; sv[1] = s2;
    cv[2] = c3; sv[2] = s3; cv[3] = c4; sv[3] = s4;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < K; i++) mw[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 est_y", longint'(est_y), 0);
    chk("R1 amp", longint'(amp), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < K; i++) chk("R1 weight zero", wget(i), 0);
    chk("R1 amp_sq", longint'(amp_sq), 0);

    // R6: only fundamental cosine, DC and A1 move by y*2^FRAC
    set_basis(16384, 0, 0, 0, 0, 0, 0, 0);
    run_sample(1000, 0, 1'b0, 1'b0);
    chk("R6 dc weight", wget(0), 1000 <<< FRAC);
    chk("R6 cos1 weight", wget(1), 1000 <<< FRAC);
    chk("R6 sin1 weight", wget(2), 0);

    // table of vectors
    for (int v = 0; v < 8; v++) begin
      set_basis(VT[v].c1, VT[v].s1, VT[v].c2, VT[v].s2, 0, 0, VT[v].c4, 0);
      run_sample(VT[v].y, int'(VT[v].mu), VT[v].mode, 1'b0);
    end

    // R8: strobe inside busy window
    set_basis(11585, -11585, 0, 16384, 16384, 0, 0, -16384);
    run_sample(-4000, 3, 1'b1, 1'b1);

    // R9: idle hold with inputs toggling but no strobe
    repeat (20) begin
      @(negedge clk);
      smp_y = smp_y + 16'sd777; cos_in = ~cos_in; mu_shift = mu_shift + 1'b1;
    end
    chk("R9 est_y held", longint'(est_y), e_y);
    chk("R9 amp held", longint'(amp), e_amp);
    for (int i = 0; i < K; i++) chk("R9 weight held", wget(i), mw[i]);

    // R5: drive weights into the rails
    set_basis(16384, 16384, 16384, 16384, 16384, 16384, 16384, 16384);
    for (int k = 0; k < 12; k++)
      run_sample((k % 2) ? -32768 : 32767, 0, k[0], 1'b0);
    n_chk++;
    if (!(wget(0) == (64'sd1 <<< (WW-1)) - 1 || wget(0) == -(64'sd1 <<< (WW-1)))) begin
      n_fail++;
      $display("FAIL R5 rail act=%0d exp=+/-%0d", wget(0), 64'sd1 <<< (WW-1));
    end

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < K; i++) chk("R1 weight after reset", wget(i), 0);
    chk("R1 est_err after reset", longint'(est_err), 0);
    rst_n = 1'b1;
    for (int i = 0; i < K; i++) mw[i] = 0;
    set_basis(0, 16384, 0, 0, 0, 0, 0, 0);
    run_sample(-2500, 1, 1'b1, 1'b0);

    summary();
  end
endmodule